// File: doc/BRIEF.md
# Non-Retriggerable Synchronous One-Shot

This block is a clocked monostable: it turns a qualified edge on one of its control inputs into a single high pulse on `q_o` whose length is a programmed number of clock cycles. It has three control inputs. `trig_fall_i` fires on a falling edge. `trig_rise_i` fires on a rising edge. `clr_n_i` is an active-low clear whose own rising edge can also fire the block. `qn_o` always carries the inverse of `q_o`.

All three control inputs are asynchronous to the clock. Each one passes through a two-flop synchronizer. An edge is then found by comparing the synchronized level with its value from the previous cycle. The pulse length is taken from `width_i` in the cycle the trigger is accepted. While a pulse runs, new edges are ignored. A low clear ends a running pulse early and locks out every trigger for as long as it stays low.

The controller has three states:
- IDLE: waiting for a trigger, `q_o` low.
- ACTIVE: pulse running, `q_o` high.
- BLOCKED: clear is held low, `q_o` low.

It has five named transitions:
- FIRE: IDLE or BLOCKED to ACTIVE, on a qualified trigger with a non-zero width.
- EXPIRE: ACTIVE to IDLE, when the down-counter reaches zero.
- ABORT: ACTIVE to BLOCKED, when the synchronized clear is low.
- HOLD: IDLE to BLOCKED, when the synchronized clear is low.
- RELEASE: BLOCKED to IDLE, when clear is high and no trigger fires.

Top module: `oneshot_pulse`

## Requirements
- R1: While `rst_n` is low, and after it is released with no trigger, `q_o` is 0 and `qn_o` is 1.
- R2: A falling edge on `trig_fall_i` starts a pulse only if `trig_rise_i` and `clr_n_i` are both high at that moment.
- R3: A rising edge on `trig_rise_i` starts a pulse only if `trig_fall_i` is low and `clr_n_i` is high. A rising edge on `trig_rise_i` while `trig_fall_i` is high does nothing.
- R4: A rising edge on `clr_n_i` starts a pulse only if `trig_fall_i` is low and `trig_rise_i` is high.
- R5: `q_o` goes high on the third rising clock edge after the triggering input changes (two synchronizer flops plus the state register). This latency is the same for every width.
- R6: `width_i` is sampled when the trigger is accepted, and `q_o` then stays high for exactly that many cycles. A width of 0 produces no pulse.
- R7: The block cannot be retriggered. Edges on any input during a pulse leave the pulse length unchanged.
- R8: A low level on `clr_n_i` during a pulse makes `q_o` low on the third rising clock edge after the change, which can cut the pulse short.
- R9: While `clr_n_i` is held low, no edge on `trig_fall_i` or `trig_rise_i` produces a pulse.
- R10: `qn_o` is the inverse of `q_o` in every cycle.
- R11: The input levels present at reset release are not taken as edges. Edge detection starts on the third clock edge after release, so A low, B high and clear high at release give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| trig_fall_i | input | 1 | Trigger input active on a falling edge (asynchronous) |
| trig_rise_i | input | 1 | Trigger input active on a rising edge (asynchronous) |
| clr_n_i | input | 1 | Active-low clear; its rising edge can also trigger (asynchronous) |
| width_i | input | WIDTH | Pulse length in clock cycles, sampled at trigger |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Inverse of `q_o` |

## Verification
A corrupted down-counter shows up at the ports as a pulse whose length differs from the programmed width, and this is visible by the cycle after the pulse should have ended. A wrong state, or a wrong edge reference, shows up as a missing pulse, an extra pulse or a late rise. The rise is due exactly three edges after the input changes, so a lost or added register stage shifts it by one cycle and is caught at once. A clear that fails to abort leaves `q_o` high past the third edge after clear falls, and a clear that fails to block lets a pulse appear while clear is low.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_BLOCKED = 2'd2
    } os_state_e;

    // Synchronizer depth and positions of the control inputs in the bundle
    localparam int SYNC_STAGES = 2;
    localparam int N_CTRL      = 3;
    localparam int IDX_FALL    = 0;
    localparam int IDX_RISE    = 1;
    localparam int IDX_CLR     = 2;

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[LAST-1:0], d_i[i]};
            end
        end

        assign q_o[i] = chain[LAST];
    end
endmodule

// File: rtl/oneshot_trigger.sv
module oneshot_trigger
    import oneshot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CTRL-1:0] lvl_i,
    output logic              hit_o,
    output logic              clr_lvl_o
);
    // Edges are ignored until the synchronizer and the previous-value
    // register both hold real samples.
    localparam int PRIME = SYNC_STAGES + 1;

    logic [N_CTRL-1:0] prev_q;
    logic [PRIME-1:0]  prime_q;
    logic              armed;
    logic              fall_edge;
    logic              rise_edge;
    logic              clr_edge;
    logic              lvl_fall;
    logic              lvl_rise;
    logic              lvl_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            prime_q <= '0;
        end else begin
            prev_q  <= lvl_i;
            prime_q <= {prime_q[PRIME-2:0], 1'b1};
        end
    end

    always_comb begin
        lvl_fall  = lvl_i[IDX_FALL];
        lvl_rise  = lvl_i[IDX_RISE];
        lvl_clr   = lvl_i[IDX_CLR];
        armed     = prime_q[PRIME-1];
        fall_edge = prev_q[IDX_FALL] & ~lvl_fall;
        rise_edge = ~prev_q[IDX_RISE] & lvl_rise;
        clr_edge  = ~prev_q[IDX_CLR] & lvl_clr;
        hit_o     = armed & ((fall_edge &  lvl_rise & lvl_clr) |
                             (rise_edge & ~lvl_fall & lvl_clr) |
                             (clr_edge  & ~lvl_fall & lvl_rise));
        clr_lvl_o = lvl_clr;
    end
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             clr_lvl_i,
    input  logic [WIDTH-1:0] width_i,
    output logic             active_o,
    output logic [WIDTH-1:0] cnt_o
);
    os_state_e        state_q, state_d;
    logic [WIDTH-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clr_lvl_i) begin
                    state_d = ST_BLOCKED;            // HOLD
                end else if (hit_i && width_i != '0) begin
                    state_d = ST_ACTIVE;             // FIRE
                    cnt_d   = width_i - 1'b1;
                end
            end
            ST_BLOCKED: begin
                if (!clr_lvl_i) begin
                    state_d = ST_BLOCKED;
                end else if (hit_i && width_i != '0) begin
                    state_d = ST_ACTIVE;             // FIRE
                    cnt_d   = width_i - 1'b1;
                end else begin
                    state_d = ST_IDLE;               // RELEASE
                end
            end
            ST_ACTIVE: begin
                if (!clr_lvl_i) begin
                    state_d = ST_BLOCKED;            // ABORT
                end else if (cnt_q == '0) begin
                    state_d = ST_IDLE;               // EXPIRE
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        active_o = (state_q == ST_ACTIVE);
        cnt_o    = cnt_q;
    end
endmodule

// File: rtl/oneshot_pulse.sv
module oneshot_pulse
    import oneshot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_fall_i,
    input  logic             trig_rise_i,
    input  logic             clr_n_i,
    input  logic [WIDTH-1:0] width_i,
    output logic             q_o,
    output logic             qn_o
);
    logic [N_CTRL-1:0] raw_lvl;
    logic [N_CTRL-1:0] sync_lvl;
    logic              trig_hit;
    logic              clr_s;
    logic              active;
    logic [WIDTH-1:0]  cnt_q;

    always_comb begin
        raw_lvl           = '0;
        raw_lvl[IDX_FALL] = trig_fall_i;
        raw_lvl[IDX_RISE] = trig_rise_i;
        raw_lvl[IDX_CLR]  = clr_n_i;
    end

    oneshot_sync #(
        .N      (N_CTRL),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_lvl),
        .q_o   (sync_lvl)
    );

    oneshot_trigger u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (sync_lvl),
        .hit_o     (trig_hit),
        .clr_lvl_o (clr_s)
    );

    oneshot_timer #(
        .WIDTH (WIDTH)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (trig_hit),
        .clr_lvl_i (clr_s),
        .width_i   (width_i),
        .active_o  (active),
        .cnt_o     (cnt_q)
    );

    assign q_o  = active;
    assign qn_o = ~active;
endmodule

// File: rtl/oneshot_pulse_chk.sv
module oneshot_pulse_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             q_o,
    input logic             qn_o,
    input logic [WIDTH-1:0] width_i,
    input logic             trig_hit,
    input logic             clr_s,
    input logic [WIDTH-1:0] cnt
);
    // R10: outputs are complementary
    a_r10_complement: assert property (@(posedge clk) disable iff (!rst_n)
        qn_o == !q_o);

    // R8, R9: a low synchronized clear forces the output low next cycle
    a_r9_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> !q_o);

    // R5: an accepted trigger with a non-zero width raises the output
    a_r5_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && width_i != '0 && !q_o && clr_s) |=> q_o);

    // R6: a zero width never starts a pulse
    a_r6_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_hit && width_i == '0 && !q_o) |=> !q_o);

    // R6, R7: a running pulse counts down by one and is not reloaded
    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && cnt != '0 && clr_s) |=> (q_o && cnt == $past(cnt) - 1'b1));

    // R1, R11: the output only rises after an accepted trigger
    a_r11_rise_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_o) |-> $past(trig_hit));
endmodule

bind oneshot_pulse oneshot_pulse_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .q_o      (q_o),
    .qn_o     (qn_o),
    .width_i  (width_i),
    .trig_hit (trig_hit),
    .clr_s    (clr_s),
    .cnt      (cnt_q)
);

// File: tb/oneshot_pulse_test.sv
module oneshot_pulse_test;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 8;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_a = 1'b0;
    logic             in_b = 1'b0;
    logic             in_c = 1'b0;
    logic [WIDTH-1:0] width = '0;
    logic             q_o;
    logic             qn_o;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // Reference model state: 0 idle, 1 pulse, 2 clear held
    logic [2:0]       m_s1, m_s2, m_prev, m_prime;
    int               m_state;
    logic [WIDTH-1:0] m_cnt;

    oneshot_pulse #(.WIDTH(WIDTH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_fall_i (in_a),
        .trig_rise_i (in_b),
        .clr_n_i     (in_c),
        .width_i     (width),
        .q_o         (q_o),
        .qn_o        (qn_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic model_hit(input logic [2:0] s2, input logic [2:0] pv,
                                       input logic armed);
        logic af, br, cr;
        af = pv[0] & ~s2[0];
        br = ~pv[1] & s2[1];
        cr = ~pv[2] & s2[2];
        return armed & ((af & s2[1] & s2[2]) | (br & ~s2[0] & s2[2]) |
                        (cr & ~s2[0] & s2[1]));
    endfunction

    task automatic model_reset();
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_prime = '0;
        m_state = 0; m_cnt = '0;
    endtask

    // One rising clock edge, applied with the inputs currently driven
    task automatic model_step();
        logic hit;
        hit = model_hit(m_s2, m_prev, m_prime[2]);
        if (!m_s2[2]) begin
            m_state = 2;
        end else if (m_state == 1) begin
            if (m_cnt == '0) m_state = 0;
            else m_cnt = m_cnt - 1'b1;
        end else if (hit && width != '0) begin
            m_state = 1;
            m_cnt   = width - 1'b1;
        end else begin
            m_state = 0;
        end
        m_prev  = m_s2;
        m_s2    = m_s1;
        m_s1    = {in_c, in_b, in_a};
        m_prime = {m_prime[1:0], 1'b1};
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) model_step();
        check_eq(cur_req, int'(q_o), (m_state == 1) ? 1 : 0);
        check_eq("R10", int'(qn_o), (m_state == 1) ? 0 : 1);
    endtask

    task automatic observe(input int n, output int highs, output int first);
        highs = 0;
        first = -1;
        for (int i = 1; i <= n; i++) begin
            tick();
            if (q_o) begin
                highs++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        int h, f, h2, f2, tot;
        void'($urandom(32'h5eed_1234));
        model_reset();

        // R1 and R11: levels that would look like a clear-rise trigger at release
        in_a = 1'b0; in_b = 1'b1; in_c = 1'b1; width = 8'd4;
        cur_req = "R1";
        tick(); tick();
        check_eq("R1", int'(q_o), 0);
        rst_n = 1'b1;
        cur_req = "R11";
        observe(8, h, f);
        check_eq("R11", h, 0);

        // R3: B rising while A is high does nothing
        cur_req = "R3";
        in_a = 1'b1; in_b = 1'b0; observe(6, h, f);
        in_b = 1'b1; observe(6, h, f);
        check_eq("R3", h, 0);

        // R2: A falling with B and clear high
        cur_req = "R2";
        width = 8'd5; in_a = 1'b0;
        observe(12, h, f);
        check_eq("R2", h, 5);
        check_eq("R5", f, 3);

        // R3: B falling is no trigger; B rising with A low fires
        cur_req = "R3";
        in_b = 1'b0; observe(6, h, f);
        check_eq("R3", h, 0);
        width = 8'd1; in_b = 1'b1;
        observe(8, h, f);
        check_eq("R3", h, 1);
        check_eq("R5", f, 3);

        // R6: zero width
        cur_req = "R6";
        in_b = 1'b0; observe(4, h, f);
        width = 8'd0; in_b = 1'b1;
        observe(8, h, f);
        check_eq("R6", h, 0);

        // R6 and R5: long width, same latency
        in_b = 1'b0; observe(4, h, f);
        width = 8'd200; in_b = 1'b1;
        observe(210, h, f);
        check_eq("R6", h, 200);
        check_eq("R5", f, 3);

        // R7: edges during the pulse do not retrigger or stretch it
        cur_req = "R7";
        in_b = 1'b0; observe(4, h, f);
        width = 8'd12; in_b = 1'b1;
        observe(4, h, f); tot = h;
        in_b = 1'b0; width = 8'd30; observe(1, h, f); tot += h;
        in_b = 1'b1; observe(1, h, f); tot += h;
        in_a = 1'b1; observe(1, h, f); tot += h;
        in_a = 1'b0; observe(30, h, f); tot += h;
        check_eq("R7", tot, 12);

        // R8: clear during a pulse cuts it short
        cur_req = "R8";
        in_b = 1'b0; observe(4, h, f);
        width = 8'd50; in_b = 1'b1;
        observe(10, h, f);
        in_c = 1'b0;
        observe(10, h2, f2);
        check_eq("R8", h + h2, 10);
        check_eq("R8", h2, 2);

        // R9: clear held low blocks all triggers
        cur_req = "R9";
        width = 8'd6; tot = 0;
        in_b = 1'b0; observe(3, h, f); tot += h;
        in_b = 1'b1; observe(3, h, f); tot += h;
        in_a = 1'b1; observe(3, h, f); tot += h;
        in_a = 1'b0; observe(3, h, f); tot += h;
        check_eq("R9", tot, 0);

        // R4: clear rising with A low and B high fires
        cur_req = "R4";
        width = 8'd7; in_c = 1'b1;
        observe(12, h, f);
        check_eq("R4", h, 7);
        check_eq("R5", f, 3);

        // R4: clear rising with A high does nothing
        in_c = 1'b0; observe(4, h, f);
        in_a = 1'b1; observe(3, h, f);
        in_c = 1'b1; observe(8, h, f);
        check_eq("R4", h, 0);

        // Random mix against the model, mostly exercising R7 and R9
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 64);
            if (r < 4) in_a = ~in_a;
            else if (r < 8) in_b = ~in_b;
            else if (r == 8) in_c = ~in_c;
            if ($urandom % 16 == 0) width = WIDTH'($urandom % 20);
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule